// File: doc/BRIEF.md
# Bitwise Identifier Arbitration Unit

This unit is the contention stage of a transmitter that shares a single open-drain bus with other nodes. On a start request it captures a frame identifier. It then sends that identifier one bit per bit-slot strobe, most significant bit first. In every slot it compares the level it drives with the level read back from the bus. The bus resolves as a logical AND of all drivers, so a 0 (dominant) from any node overrides a 1 (recessive). A node that sends a 1 but reads back a 0 has been outranked. It withdraws without disturbing the bits of the node that outranked it. As a result, the node with the lowest numeric identifier finishes unharmed.

After a loss the unit drives recessive and reports the slot index at which it lost. It refuses new start requests until an external bus-idle indication is seen. A node that gets through every identifier bit without a loss reports a win. Bit timing, stuffing, CRC and the data phase belong to neighbouring blocks. A plain slot strobe stands in for the bit-timing logic.

Top module: `can_id_arbiter`

## Requirements
- R1: During and after a synchronous active-low reset, `tx_o` is 1 (recessive), `busy_o` is 0, and `won_o` and `lost_o` are 0.
- R2: When the unit is idle, a `start_i` sampled high at a clock edge captures `ident_i`. From the next cycle `busy_o` is 1 and `tx_o` presents bit ID_W-1 of the captured identifier.
- R3: Identifier bits are sent most significant first. `tx_o` moves to the next lower bit only at a clock edge where `slot_i` is high, and holds between strobes.
- R4: At a strobe edge where `tx_o` is 1 and `bus_rx_i` is 0, the unit loses. In the next cycle `lost_o` is high for exactly one cycle and `lost_idx_o` holds the slot index of the loss, where index 0 is the first (most significant) bit.
- R5: After a loss, `tx_o` stays 1 and `busy_o` stays 0, and `start_i` has no effect, until `bus_idle_i` has been sampled high. After that a start is accepted again.
- R6: If the strobe edge of the last identifier bit passes without a loss, `won_o` is high for exactly one cycle in the next cycle, and the unit returns to idle with `tx_o` at 1.
- R7: `won_o` and `lost_o` are never high in the same cycle.
- R8: `start_i` while the unit is sending has no effect on the bits being sent.
- R9: A bit that the unit drives as 0 never causes a loss, whatever level is read back.
- R10: When several units share the AND bus and start together, only the one with the lowest identifier wins. Every other unit loses at the first index where its identifier differs from the lowest one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request to begin arbitration with `ident_i` |
| ident_i | input | ID_W | Identifier to contend with |
| slot_i | input | 1 | Bit-slot strobe: sample the bus and advance |
| bus_rx_i | input | 1 | Bus level read back (0 dominant) |
| bus_idle_i | input | 1 | Bus reported idle; releases the lockout after a loss |
| tx_o | output | 1 | Level driven onto the bus (1 recessive) |
| busy_o | output | 1 | Identifier transmission in progress |
| won_o | output | 1 | One-cycle pulse: arbitration won |
| lost_o | output | 1 | One-cycle pulse: arbitration lost |
| lost_idx_o | output | IDX_W | Slot index of the loss, valid while `lost_o` is high |

## Verification
The bench joins three units through an AND of their drive outputs. It aims at identifiers that share long common prefixes, where a unit that sampled the bus one slot late or early would report a loss at the wrong index. An identifier of all ones is used, and so is an all-zero identifier that wins at slot 0. A lone node must win by hearing only its own recessive bits. Two kinds of stray request are tried. A start in the lockout would put a lost node back on the wire, and a start in mid-frame would reload the shifter and corrupt the bits that follow. Identical identifiers are also sent, to catch a unit that treats a dominant-vs-dominant slot as a loss.

// File: rtl/can_arb_pkg.sv
// Package: shared types for the identifier arbitration unit.
// Assumes: nothing beyond IEEE 1800-2017.
package can_arb_pkg;
    typedef enum logic [1:0] {
        ARB_IDLE = 2'd0,   // waiting for a start request
        ARB_SEND = 2'd1,   // shifting identifier bits out
        ARB_LOCK = 2'd2    // lost; recessive until bus idle
    } arb_state_e;
endpackage

// File: rtl/arb_id_shifter.sv
// Identifier shift register. Holds the identifier being sent and
// presents its current bit on msb_o. It fills with ones (recessive)
// as it shifts.
// Assumes: load and shift are never high together.
module arb_id_shifter #(
    parameter int ID_W = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic            shift_i,
    input  logic [ID_W-1:0] ident_i,
    output logic            msb_o
);
    logic [ID_W-1:0] sh_q;

    // Capture the identifier on load, move one bit on shift.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sh_q <= '1;
        else if (load_i)
            sh_q <= ident_i;
        else if (shift_i)
            sh_q <= {sh_q[ID_W-2:0], 1'b1};
    end

    assign msb_o = sh_q[ID_W-1];

    // R3: after a shift the bit presented is what sat one below it.
    p_shift_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_i && !load_i) |=> (msb_o == $past(sh_q[ID_W-2])));
endmodule

// File: rtl/arb_bit_counter.sv
// Slot index counter. Counts identifier bits already compared and
// flags the last one.
// Assumes: inc_i is only raised while index is below ID_W-1.
module arb_bit_counter #(
    parameter int ID_W  = 11,
    parameter int IDX_W = $clog2(ID_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             last_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ID_W - 1);

    logic [IDX_W-1:0] cnt_q;

    // Clear at frame start, step once per compared slot.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr_i)
            cnt_q <= '0;
        else if (inc_i)
            cnt_q <= cnt_q + 1'b1;
    end

    assign idx_o  = cnt_q;
    assign last_o = (cnt_q == LAST_IDX);

    // R3: the index never runs past the identifier width.
    p_idx_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_IDX);
endmodule

// File: rtl/arb_ctrl.sv
// Arbitration sequencer. Decides on each slot strobe whether to advance,
// withdraw or finish, and emits the registered win/loss pulses.
// Assumes: tx_bit_i is the bit driven in the current slot and bus_rx_i
// is the bus level sampled for that same slot.
module arb_ctrl
    import can_arb_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             slot_i,
    input  logic             tx_bit_i,
    input  logic             bus_rx_i,
    input  logic             bus_idle_i,
    input  logic             last_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic             load_o,
    output logic             shift_o,
    output logic             clr_o,
    output logic             sending_o,
    output logic             won_o,
    output logic             lost_o,
    output logic [IDX_W-1:0] lost_idx_o
);
    arb_state_e state_q, state_d;
    logic       lose_now;

    // A recessive bit overwritten by a dominant one means we were outranked.
    assign lose_now = slot_i && tx_bit_i && !bus_rx_i;

    // Next-state and datapath strobes.
    always_comb begin
        state_d = state_q;
        load_o  = 1'b0;
        shift_o = 1'b0;
        clr_o   = 1'b0;
        unique case (state_q)
            ARB_IDLE: begin
                if (start_i) begin
                    load_o  = 1'b1;
                    clr_o   = 1'b1;
                    state_d = ARB_SEND;
                end
            end
            ARB_SEND: begin
                if (lose_now)
                    state_d = ARB_LOCK;
                else if (slot_i && last_i)
                    state_d = ARB_IDLE;
                else if (slot_i)
                    shift_o = 1'b1;
            end
            ARB_LOCK: begin
                if (bus_idle_i)
                    state_d = ARB_IDLE;
            end
            default: state_d = ARB_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ARB_IDLE;
        else
            state_q <= state_d;
    end

    // One-cycle outcome pulses and the captured loss index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            won_o      <= 1'b0;
            lost_o     <= 1'b0;
            lost_idx_o <= '0;
        end else begin
            won_o  <= (state_q == ARB_SEND) && slot_i && last_i && !lose_now;
            lost_o <= (state_q == ARB_SEND) && lose_now;
            if ((state_q == ARB_SEND) && lose_now)
                lost_idx_o <= idx_i;
        end
    end

    assign sending_o = (state_q == ARB_SEND);

    // R7: outcome pulses are mutually exclusive.
    p_pulse_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(won_o && lost_o));
    // R6: a win lasts one cycle.
    p_won_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        won_o |=> !won_o);
    // R4: a loss lasts one cycle.
    p_lost_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lost_o |=> !lost_o);
    // R5: a lockout ends only through bus idle.
    p_lock_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ARB_LOCK && !bus_idle_i) |=> (state_q == ARB_LOCK));
endmodule

// File: rtl/can_id_arbiter.sv
// Top of the identifier arbitration unit. Joins the shifter, the slot
// counter and the sequencer, and forces the bus output recessive
// whenever no identifier is being sent.
// Assumes: bus_rx_i is already synchronised and sampled for the slot
// marked by slot_i; slot_i is a single-cycle strobe.
module can_id_arbiter #(
    parameter int ID_W  = 11,
    parameter int IDX_W = $clog2(ID_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [ID_W-1:0]  ident_i,
    input  logic             slot_i,
    input  logic             bus_rx_i,
    input  logic             bus_idle_i,
    output logic             tx_o,
    output logic             busy_o,
    output logic             won_o,
    output logic             lost_o,
    output logic [IDX_W-1:0] lost_idx_o
);
    logic             load, shift, clr, sending, cur_bit, last;
    logic [IDX_W-1:0] idx;

    arb_id_shifter #(.ID_W(ID_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .shift_i (shift),
        .ident_i (ident_i),
        .msb_o   (cur_bit)
    );

    arb_bit_counter #(.ID_W(ID_W), .IDX_W(IDX_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (clr),
        .inc_i  (shift),
        .idx_o  (idx),
        .last_o (last)
    );

    arb_ctrl #(.IDX_W(IDX_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .slot_i     (slot_i),
        .tx_bit_i   (cur_bit),
        .bus_rx_i   (bus_rx_i),
        .bus_idle_i (bus_idle_i),
        .last_i     (last),
        .idx_i      (idx),
        .load_o     (load),
        .shift_o    (shift),
        .clr_o      (clr),
        .sending_o  (sending),
        .won_o      (won_o),
        .lost_o     (lost_o),
        .lost_idx_o (lost_idx_o)
    );

    // Drive the identifier bit only while contending; recessive otherwise.
    assign tx_o   = sending ? cur_bit : 1'b1;
    assign busy_o = sending;

    // R4: every loss traces back to a recessive-driven, dominant-read strobe.
    p_loss_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lost_o |-> $past(slot_i && tx_o && !bus_rx_i));
    // R5: right after a loss the node is off the wire.
    p_loss_recessive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lost_o |-> (tx_o && !busy_o));
    // R3: without a strobe the driven bit holds during transmission.
    p_hold_no_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o) && !$past(slot_i)) |-> (tx_o == $past(tx_o)));
    // R9: a dominant bit never ends in a loss.
    p_dominant_safe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !tx_o && slot_i) |=> !lost_o);
endmodule

// File: tb/sim_can_id_arbiter.sv
module sim_can_id_arbiter;
    localparam int ID_W  = 11;
    localparam int IDX_W = $clog2(ID_W);
    localparam int N     = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [N-1:0]      start = '0;
    logic [ID_W-1:0]   ids [N];
    logic              slot = 1'b0;
    logic              idle = 1'b0;
    logic [N-1:0]      tx, busy, won, lost;
    logic [IDX_W-1:0]  lidx [N];
    logic              bus;

    assign bus = &tx;   // wired-AND bus

    initial for (int i = 0; i < N; i++) ids[i] = '1;

    can_id_arbiter #(.ID_W(ID_W)) u0 (.clk(clk), .rst_n(rst_n), .start_i(start[0]),
        .ident_i(ids[0]), .slot_i(slot), .bus_rx_i(bus), .bus_idle_i(idle),
        .tx_o(tx[0]), .busy_o(busy[0]), .won_o(won[0]), .lost_o(lost[0]), .lost_idx_o(lidx[0]));
    can_id_arbiter #(.ID_W(ID_W)) u1 (.clk(clk), .rst_n(rst_n), .start_i(start[1]),
        .ident_i(ids[1]), .slot_i(slot), .bus_rx_i(bus), .bus_idle_i(idle),
        .tx_o(tx[1]), .busy_o(busy[1]), .won_o(won[1]), .lost_o(lost[1]), .lost_idx_o(lidx[1]));
    can_id_arbiter #(.ID_W(ID_W)) u2 (.clk(clk), .rst_n(rst_n), .start_i(start[2]),
        .ident_i(ids[2]), .slot_i(slot), .bus_rx_i(bus), .bus_idle_i(idle),
        .tx_o(tx[2]), .busy_o(busy[2]), .won_o(won[2]), .lost_o(lost[2]), .lost_idx_o(lidx[2]));

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // ---- behavioural reference model: 0 idle, 1 sending, 2 locked out ----
    int              m_st [N];
    int              m_pos [N];
    logic [ID_W-1:0] m_id [N];
    bit              m_won [N];
    bit              m_lost [N];
    int              m_lidx [N];

    always @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (!rst_n) begin
                m_st[i] <= 0; m_pos[i] <= 0; m_id[i] <= '1;
                m_won[i] <= 0; m_lost[i] <= 0; m_lidx[i] <= 0;
            end else begin
                m_won[i]  <= 0;
                m_lost[i] <= 0;
                if (m_st[i] == 0) begin
                    if (start[i]) begin
                        m_st[i] <= 1; m_pos[i] <= 0; m_id[i] <= ids[i];
                    end
                end else if (m_st[i] == 1) begin
                    if (slot) begin
                        if (m_id[i][ID_W-1-m_pos[i]] == 1'b1 && bus == 1'b0) begin
                            m_lost[i] <= 1; m_lidx[i] <= m_pos[i]; m_st[i] <= 2;
                        end else if (m_pos[i] == ID_W-1) begin
                            m_won[i] <= 1; m_st[i] <= 0;
                        end else begin
                            m_pos[i] <= m_pos[i] + 1;
                        end
                    end
                end else begin
                    if (idle) m_st[i] <= 0;
                end
            end
        end
    end

    function automatic logic exp_tx(int i);
        return (m_st[i] == 1) ? m_id[i][ID_W-1-m_pos[i]] : 1'b1;
    endfunction

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            for (int i = 0; i < N; i++) begin
                checks++;
                if (tx[i] !== exp_tx(i)) begin
                    failures++;
                    $display("FAIL R3 node %0d tx act=%b exp=%b t=%0t", i, tx[i], exp_tx(i), $time);
                end
                checks++;
                if (busy[i] !== (m_st[i] == 1)) begin
                    failures++;
                    $display("FAIL R2 node %0d busy act=%b exp=%b", i, busy[i], (m_st[i] == 1));
                end
                checks++;
                if (won[i] !== m_won[i]) begin
                    failures++;
                    $display("FAIL R6 node %0d won act=%b exp=%b", i, won[i], m_won[i]);
                end
                checks++;
                if (lost[i] !== m_lost[i]) begin
                    failures++;
                    $display("FAIL R4 node %0d lost act=%b exp=%b", i, lost[i], m_lost[i]);
                end
                if (lost[i] && m_lost[i]) begin
                    checks++;
                    if (int'(lidx[i]) != m_lidx[i]) begin
                        failures++;
                        $display("FAIL R4 node %0d lost_idx act=%0d exp=%0d", i, lidx[i], m_lidx[i]);
                    end
                end
            end
        end
    end

    // ---- system-level outcome tracking (R10) ----
    logic [N-1:0]    part = '0;
    logic [ID_W-1:0] r_id [N];
    int              win_cnt = 0;

    function automatic int first_diff(logic [ID_W-1:0] a, logic [ID_W-1:0] b);
        for (int k = 0; k < ID_W; k++)
            if (a[ID_W-1-k] != b[ID_W-1-k]) return k;
        return -1;
    endfunction

    function automatic logic [ID_W-1:0] min_id();
        logic [ID_W-1:0] m = '1;
        for (int i = 0; i < N; i++)
            if (part[i] && r_id[i] < m) m = r_id[i];
        return m;
    endfunction

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            for (int i = 0; i < N; i++) begin
                if (won[i]) begin
                    win_cnt++;
                    checks++;
                    if (r_id[i] != min_id()) begin
                        failures++;
                        $display("FAIL R10 node %0d won with id act=%h exp=%h", i, r_id[i], min_id());
                    end
                end
                if (lost[i]) begin
                    checks++;
                    if (int'(lidx[i]) != first_diff(r_id[i], min_id())) begin
                        failures++;
                        $display("FAIL R10 node %0d loss index act=%0d exp=%0d", i, lidx[i],
                                 first_diff(r_id[i], min_id()));
                    end
                end
            end
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    // One contest: release lockouts, start the masked nodes, run all slots.
    task automatic round(logic [N-1:0] mask, logic [ID_W-1:0] a, logic [ID_W-1:0] b,
                         logic [ID_W-1:0] c, int exp_wins);
        idle = 1'b1; tick(1); idle = 1'b0;
        ids[0] = a; ids[1] = b; ids[2] = c;
        r_id[0] = a; r_id[1] = b; r_id[2] = c;
        part = mask; win_cnt = 0;
        start = mask; tick(1); start = '0;
        for (int s = 0; s < ID_W; s++) begin
            tick(2);
            slot = 1'b1; tick(1); slot = 1'b0;
        end
        tick(3);
        checks++;
        if (win_cnt != exp_wins) begin
            failures++;
            $display("FAIL R10 winners act=%0d exp=%0d", win_cnt, exp_wins);
        end
    endtask

    initial begin
        tick(3);
        // R1: reset state (checked while reset is still asserted)
        for (int i = 0; i < N; i++) begin
            checks++;
            if (tx[i] !== 1'b1 || busy[i] !== 1'b0 || won[i] !== 1'b0 || lost[i] !== 1'b0) begin
                failures++;
                $display("FAIL R1 node %0d tx/busy/won/lost act=%b%b%b%b exp=1000", i, tx[i], busy[i], won[i], lost[i]);
            end
        end
        rst_n = 1'b1;
        tick(2);

        // R10/R4: shared prefix, loss at index 8 for 0x125 and index 1 for 0x3FF
        round(3'b111, 11'h123, 11'h125, 11'h3FF, 1);

        // R5: start in lockout is ignored; tx stays recessive
        ids[1] = 11'h000;
        start = 3'b010; tick(1); start = '0; tick(4);
        checks++;
        if (tx[1] !== 1'b1 || busy[1] !== 1'b0) begin
            failures++;
            $display("FAIL R5 lockout start act tx=%b busy=%b exp tx=1 busy=0", tx[1], busy[1]);
        end

        // R6: lone node of all-recessive bits wins
        round(3'b100, 11'h7FF, 11'h7FF, 11'h7FF, 1);
        // R10: all-zero identifier wins from slot 0
        round(3'b111, 11'h400, 11'h000, 11'h555, 1);
        // R9: identical identifiers both finish without loss
        round(3'b011, 11'h2A5, 11'h2A5, 11'h7FF, 2);
        // R2/R5: node that lost earlier starts again after bus idle
        round(3'b111, 11'h7FE, 11'h7FD, 11'h7FC, 1);

        // R8: a start during sending leaves the frame untouched
        idle = 1'b1; tick(1); idle = 1'b0;
        ids[0] = 11'h0F0; r_id[0] = 11'h0F0; part = 3'b001; win_cnt = 0;
        start = 3'b001; tick(1); start = '0;
        for (int s = 0; s < ID_W; s++) begin
            tick(1);
            if (s == 4) begin ids[0] = 11'h7FF; start = 3'b001; end
            tick(1); start = '0;
            slot = 1'b1; tick(1); slot = 1'b0;
        end
        ids[0] = 11'h0F0;
        tick(3);
        checks++;
        if (win_cnt != 1) begin
            failures++;
            $display("FAIL R8 restart mid-frame winners act=%0d exp=1", win_cnt);
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule